// File: doc/BRIEF.md
# Windowed Watchdog Timer

This block is a watchdog counter that software must service by writing a fixed key byte to a service register. Each count period is split into a closed part at its start and an open part at its end, up to the overflow point. A key write in the open part restarts the count from zero. A key write in the closed part, any write of a value other than the key, or a period that runs out without a service all raise a one-cycle reset request for the system reset logic.

The length of the period and the size of the open part come from static option bits that are captured while reset is held. The first key write after reset, or after a reset request, is exempt from the window check, so start-up code can service the watchdog at any point before the first overflow. When the standby-enable option bit is clear, the open part covers the whole period.

Top module: `svc_window_watchdog`

## Requirements
- R1: While `rst_n` is low and on the first cycles after its release, `rst_req` is 0; the count starts from zero at release and the first-write exemption is armed.
- R2: With overflow select `n`, the period is P = 2^(BASE_EXP+n) clock cycles (BASE_EXP is 10 by default). Without a valid service, `rst_req` is high in the cycle after the P-th rising edge counted from reset release or from the last restart, and low in every cycle before it.
- R3: A write of the key 0xAC that lands in the open part restarts the count at zero and gives no reset request, so the next overflow comes a full period later.
- R4: After the exemption is used, a key write that lands in the closed part gives a reset request in the cycle after the write.
- R5: A write of any value other than 0xAC gives a reset request in the cycle after the write, in either part of the period and even as the first write.
- R6: The 2-bit window field selects the closed part: 01 closes counts 0 to P/2-1, 10 closes counts 0 to P/4-1, 11 closes nothing; the reserved code 00 behaves like 11.
- R7: When the standby-enable bit is 0, no count is closed, whatever the window field holds.
- R8: The first key write after reset release restarts the count at zero in any part of the period, without a reset request.
- R9: A reset request returns the block to its post-reset state: the count restarts from zero and the first-write exemption is armed again.
- R10: The option bits are captured on each clock edge while `rst_n` is low; changes on them after release have no effect until the next reset.
- R11: A reset request lasts exactly one cycle unless a new fault arrives in that cycle.
- R12: A key write on the final count of the period (count P-1) is a valid service and prevents the overflow.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock of the count |
| rst_n | input | 1 | Active-low reset; option bits are captured while it is low |
| wr_en | input | 1 | Strobe for a write to the service register |
| wr_data | input | DATA_W | Byte written to the service register |
| cfg_window | input | 2 | Open-window select (01 half, 10 three quarters, 11 or 00 whole period) |
| cfg_ovf_sel | input | SEL_W | Overflow select n, period 2^(BASE_EXP+n) cycles |
| cfg_stby_en | input | 1 | Standby-enable option; 0 forces the whole period open |
| rst_req | output | 1 | One-cycle internal reset request |

## Verification
The case hardest to reach from the ports is a key write inside the closed part, because the first write after every reset or reset request is exempt and the bench has to spend that exemption before the window rule applies at all. The stimulus therefore makes an exempt write first, counts cycles from the restart it causes, and then writes at counts one below and exactly at the closed-part boundary, as well as on the last count of the period. Option capture is reached by changing the option pins right after release and showing that the boundary and overflow still follow the captured values.

// File: rtl/wwd_pkg.sv
package wwd_pkg;

  typedef enum logic [1:0] {
    WIN_RSVD = 2'b00,
    WIN_HALF = 2'b01,
    WIN_3Q   = 2'b10,
    WIN_FULL = 2'b11
  } win_code_e;

  typedef enum logic [1:0] {
    FLT_NONE   = 2'd0,
    FLT_KEY    = 2'd1,
    FLT_CLOSED = 2'd2,
    FLT_OVF    = 2'd3
  } fault_kind_e;

endpackage

// File: rtl/wwd_cfg_hold.sv
module wwd_cfg_hold
  import wwd_pkg::*;
#(
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       win_in,
  input  logic [SEL_W-1:0] sel_in,
  input  logic             stby_in,
  output win_code_e        win_q,
  output logic [SEL_W-1:0] sel_q,
  output logic             stby_q
);

  // Option bits follow the pins only while reset is held.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      win_q  <= win_code_e'(win_in);
      sel_q  <= sel_in;
      stby_q <= stby_in;
    end
  end

endmodule

// File: rtl/wwd_window_calc.sv
module wwd_window_calc
  import wwd_pkg::*;
#(
  parameter int BASE_EXP = 10,
  parameter int SEL_W    = 3,
  parameter int CNT_W    = BASE_EXP + (1 << SEL_W) - 1
) (
  input  win_code_e        win_q,
  input  logic [SEL_W-1:0] sel_q,
  input  logic             stby_q,
  output win_code_e        win_eff,
  output logic [CNT_W-1:0] last_cnt,
  output logic [CNT_W-1:0] closed_thr
);

  localparam int MAX_SEL = (1 << SEL_W) - 1;
  localparam logic [CNT_W-1:0] ALL_ONES = '1;

  // Final count of a period of 2^(BASE_EXP+sel) cycles.
  function automatic logic [CNT_W-1:0] f_last(input logic [SEL_W-1:0] sel);
    return ALL_ONES >> (MAX_SEL - int'(sel));
  endfunction

  // First open count: the period times the closed fraction, by shifts.
  function automatic logic [CNT_W-1:0] f_closed(input logic [CNT_W-1:0] last,
                                                input win_code_e      win);
    logic [CNT_W:0] per;
    logic [CNT_W:0] thr;
    per = {1'b0, last} + (CNT_W+1)'(1);
    case (win)
      WIN_HALF: thr = per >> 1;
      WIN_3Q:   thr = per >> 2;
      default:  thr = '0;
    endcase
    return thr[CNT_W-1:0];
  endfunction

  // Reserved code and standby-disabled both mean a fully open period.
  function automatic win_code_e f_effective(input win_code_e win, input logic stby);
    if (!stby || win == WIN_RSVD) return WIN_FULL;
    return win;
  endfunction

  always_comb begin
    win_eff    = f_effective(win_q, stby_q);
    last_cnt   = f_last(sel_q);
    closed_thr = f_closed(last_cnt, win_eff);
  end

endmodule

// File: rtl/wwd_period_cnt.sv
module wwd_period_cnt #(
  parameter int CNT_W = 17
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  output logic [CNT_W-1:0] cnt
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (restart) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + CNT_W'(1);
    end
  end

endmodule

// File: rtl/wwd_service_judge.sv
module wwd_service_judge
  import wwd_pkg::*;
#(
  parameter int              DATA_W = 8,
  parameter int              CNT_W  = 17,
  parameter logic [DATA_W-1:0] KEY  = 8'hAC
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [CNT_W-1:0]  cnt,
  input  logic [CNT_W-1:0]  last_cnt,
  input  logic [CNT_W-1:0]  closed_thr,
  output logic              in_open,
  output logic              ovf_hit,
  output logic              svc_accept,
  output fault_kind_e       fault_kind,
  output logic              fault_evt,
  output logic              restart,
  output logic              first_pend,
  output logic              rst_req
);

  logic key_match;

  always_comb begin
    key_match  = (wr_data == KEY);
    in_open    = (cnt >= closed_thr);
    ovf_hit    = (cnt == last_cnt);
    svc_accept = wr_en && key_match && (first_pend || in_open);

    if (wr_en && !key_match)        fault_kind = FLT_KEY;
    else if (wr_en && !svc_accept)  fault_kind = FLT_CLOSED;
    else if (ovf_hit && !svc_accept) fault_kind = FLT_OVF;
    else                            fault_kind = FLT_NONE;

    fault_evt = (fault_kind != FLT_NONE);
    restart   = svc_accept || fault_evt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      first_pend <= 1'b1;
      rst_req    <= 1'b0;
    end else begin
      rst_req <= fault_evt;
      if (fault_evt)       first_pend <= 1'b1;
      else if (svc_accept) first_pend <= 1'b0;
    end
  end

endmodule

// File: rtl/svc_window_watchdog.sv
module svc_window_watchdog
  import wwd_pkg::*;
#(
  parameter int                BASE_EXP = 10,
  parameter int                SEL_W    = 3,
  parameter int                DATA_W   = 8,
  parameter logic [DATA_W-1:0] KEY      = 8'hAC
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [1:0]        cfg_window,
  input  logic [SEL_W-1:0]  cfg_ovf_sel,
  input  logic              cfg_stby_en,
  output logic              rst_req
);

  localparam int CNT_W = BASE_EXP + (1 << SEL_W) - 1;

  win_code_e        win_q;
  win_code_e        win_eff;
  logic [SEL_W-1:0] sel_q;
  logic             stby_q;
  logic [CNT_W-1:0] last_cnt;
  logic [CNT_W-1:0] closed_thr;
  logic [CNT_W-1:0] cnt;
  logic             in_open;
  logic             ovf_hit;
  logic             svc_accept;
  fault_kind_e      fault_kind;
  logic             fault_evt;
  logic             restart;
  logic             first_pend;

  wwd_cfg_hold #(.SEL_W(SEL_W)) u_cfg (
    .clk     (clk),
    .rst_n   (rst_n),
    .win_in  (cfg_window),
    .sel_in  (cfg_ovf_sel),
    .stby_in (cfg_stby_en),
    .win_q   (win_q),
    .sel_q   (sel_q),
    .stby_q  (stby_q)
  );

  wwd_window_calc #(.BASE_EXP(BASE_EXP), .SEL_W(SEL_W), .CNT_W(CNT_W)) u_win (
    .win_q      (win_q),
    .sel_q      (sel_q),
    .stby_q     (stby_q),
    .win_eff    (win_eff),
    .last_cnt   (last_cnt),
    .closed_thr (closed_thr)
  );

  wwd_period_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (restart),
    .cnt     (cnt)
  );

  wwd_service_judge #(.DATA_W(DATA_W), .CNT_W(CNT_W), .KEY(KEY)) u_judge (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_data    (wr_data),
    .cnt        (cnt),
    .last_cnt   (last_cnt),
    .closed_thr (closed_thr),
    .in_open    (in_open),
    .ovf_hit    (ovf_hit),
    .svc_accept (svc_accept),
    .fault_kind (fault_kind),
    .fault_evt  (fault_evt),
    .restart    (restart),
    .first_pend (first_pend),
    .rst_req    (rst_req)
  );

endmodule

// File: rtl/wwd_checker.sv
module wwd_checker #(
  parameter int                DATA_W = 8,
  parameter int                CNT_W  = 17,
  parameter logic [DATA_W-1:0] KEY    = 8'hAC
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [DATA_W-1:0] wr_data,
  input logic [CNT_W-1:0]  cnt,
  input logic [CNT_W-1:0]  last_cnt,
  input logic [CNT_W-1:0]  closed_thr,
  input logic              first_pend,
  input logic              rst_req
);

  a_r2_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == last_cnt && !wr_en) |=> rst_req);

  a_r2_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= last_cnt);

  a_r3_open_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data == KEY && cnt >= closed_thr) |=> (!rst_req && cnt == '0));

  a_r4_closed_fault: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data == KEY && !first_pend && cnt < closed_thr) |=> rst_req);

  a_r5_bad_key: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data != KEY) |=> rst_req);

  a_r8_first_exempt: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data == KEY && first_pend) |=> (!rst_req && cnt == '0 && !first_pend));

  a_r9_post_fault_state: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> (cnt == '0 && first_pend));

  a_r11_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> (!rst_req || $past(wr_en)));

endmodule

bind svc_window_watchdog wwd_checker #(
  .DATA_W (DATA_W),
  .CNT_W  (CNT_W),
  .KEY    (KEY)
) u_wwd_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .wr_en      (wr_en),
  .wr_data    (wr_data),
  .cnt        (cnt),
  .last_cnt   (last_cnt),
  .closed_thr (closed_thr),
  .first_pend (first_pend),
  .rst_req    (rst_req)
);

// File: tb/tb_svc_window_watchdog.sv
module tb_svc_window_watchdog;

  localparam int CLK_PERIOD = 10;
  localparam int BASE_EXP   = 4;
  localparam int SEL_W      = 3;
  localparam logic [7:0] KEY = 8'hAC;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             wr_en = 1'b0;
  logic [7:0]       wr_data = '0;
  logic [1:0]       cfg_window = 2'b11;
  logic [SEL_W-1:0] cfg_ovf_sel = '0;
  logic             cfg_stby_en = 1'b1;
  logic             rst_req;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  svc_window_watchdog #(.BASE_EXP(BASE_EXP), .SEL_W(SEL_W), .DATA_W(8), .KEY(KEY)) dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (wr_en),
    .wr_data     (wr_data),
    .cfg_window  (cfg_window),
    .cfg_ovf_sel (cfg_ovf_sel),
    .cfg_stby_en (cfg_stby_en),
    .rst_req     (rst_req)
  );

  // Expected timing, from the requirements.
  function automatic int period_of(input int sel);
    return 1 << (BASE_EXP + sel);
  endfunction

  function automatic int closed_of(input int win, input int sel, input bit stby);
    if (!stby) return 0;
    if (win == 1) return period_of(sel) / 2;
    if (win == 2) return period_of(sel) / 4;
    return 0;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic start(input logic [1:0] win, input int sel, input bit stby);
    @(negedge clk);
    rst_n       = 1'b0;
    wr_en       = 1'b0;
    cfg_window  = win;
    cfg_ovf_sel = SEL_W'(sel);
    cfg_stby_en = stby;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  // Let n edges pass; return how many reset pulses were seen.
  task automatic idle(input int n, output int pulses);
    pulses = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (rst_req) pulses++;
    end
  endtask

  task automatic write(input logic [7:0] d);
    wr_en   = 1'b1;
    wr_data = d;
    @(negedge clk);
    wr_en   = 1'b0;
  endtask

  task automatic quiet_then(input int n, input string req);
    int p;
    idle(n, p);
    check(p == 0, req, p, 0);
  endtask

  task automatic t_reset_and_overflow();
    int p = period_of(0);
    start(2'b11, 0, 1'b1);
    check(rst_req == 1'b0, "R1", int'(rst_req), 0);
    quiet_then(p - 1, "R2");
    idle(1, p);
    check(rst_req == 1'b1, "R2", int'(rst_req), 1);
    idle(1, p);
    check(rst_req == 1'b0, "R11", int'(rst_req), 0);
  endtask

  task automatic t_reset_hold();
    @(negedge clk);
    rst_n = 1'b0;
    wr_en = 1'b1;
    wr_data = 8'h00;
    repeat (3) @(negedge clk);
    check(rst_req == 1'b0, "R1", int'(rst_req), 0);
    wr_en = 1'b0;
  endtask

  task automatic t_long_period();
    int p = period_of(2);
    int q;
    start(2'b11, 2, 1'b1);
    quiet_then(p - 1, "R2");
    idle(1, q);
    check(rst_req == 1'b1, "R2", int'(rst_req), 1);
  endtask

  task automatic t_first_then_closed();
    int thr = closed_of(1, 1, 1'b1);
    int q;
    start(2'b01, 1, 1'b1);
    idle(3, q);
    write(KEY);
    check(rst_req == 1'b0, "R8", int'(rst_req), 0);
    idle(3, q);
    write(KEY);
    check(rst_req == 1'b1 && thr > 3, "R4", int'(rst_req), 1);
  endtask

  task automatic t_half_window();
    int p = period_of(0);
    int thr = closed_of(1, 0, 1'b1);
    int q;
    start(2'b01, 0, 1'b1);
    idle(1, q);
    write(KEY);
    idle(thr - 1, q);
    write(KEY);
    check(rst_req == 1'b1, "R6", int'(rst_req), 1);
    idle(2, q);
    write(KEY);
    check(rst_req == 1'b0, "R9", int'(rst_req), 0);
    idle(thr, q);
    write(KEY);
    check(rst_req == 1'b0, "R3", int'(rst_req), 0);
    idle(p - 1, q);
    write(KEY);
    check(rst_req == 1'b0 && q == 0, "R12", int'(rst_req), 0);
    quiet_then(p - 1, "R3");
    idle(1, q);
    check(rst_req == 1'b1, "R3", int'(rst_req), 1);
  endtask

  task automatic t_quarter_window();
    int thr = closed_of(2, 0, 1'b1);
    int q;
    start(2'b10, 0, 1'b1);
    write(KEY);
    idle(thr - 1, q);
    write(KEY);
    check(rst_req == 1'b1, "R6", int'(rst_req), 1);
    write(KEY);
    idle(thr, q);
    write(KEY);
    check(rst_req == 1'b0, "R6", int'(rst_req), 0);
  endtask

  task automatic t_full_windows();
    start(2'b11, 0, 1'b1);
    write(KEY);
    write(KEY);
    check(rst_req == 1'b0, "R6", int'(rst_req), 0);
    start(2'b00, 0, 1'b1);
    write(KEY);
    write(KEY);
    check(rst_req == 1'b0, "R6", int'(rst_req), 0);
  endtask

  task automatic t_standby_off();
    int q;
    start(2'b01, 0, 1'b0);
    write(KEY);
    idle(1, q);
    write(KEY);
    check(rst_req == 1'b0, "R7", int'(rst_req), 0);
  endtask

  task automatic t_bad_key();
    int q;
    start(2'b11, 0, 1'b1);
    write(8'h5A);
    check(rst_req == 1'b1, "R5", int'(rst_req), 1);
    write(KEY);
    idle(5, q);
    write(8'hAD);
    check(rst_req == 1'b1, "R5", int'(rst_req), 1);
  endtask

  task automatic t_cfg_held();
    int p = period_of(0);
    int q;
    start(2'b01, 0, 1'b1);
    cfg_window  = 2'b11;
    cfg_ovf_sel = SEL_W'(3);
    cfg_stby_en = 1'b0;
    idle(2, q);
    write(KEY);
    idle(3, q);
    write(KEY);
    check(rst_req == 1'b1, "R10", int'(rst_req), 1);
    quiet_then(p - 1, "R10");
    idle(1, q);
    check(rst_req == 1'b1, "R10", int'(rst_req), 1);
  endtask

  initial begin
    t_reset_hold();
    t_reset_and_overflow();
    t_long_period();
    t_first_then_closed();
    t_half_window();
    t_quarter_window();
    t_full_windows();
    t_standby_off();
    t_bad_key();
    t_cfg_held();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule